// File: doc/BRIEF.md
# Dispatch Slot Guard

This block keeps track of how full the current in-order dispatch group is. It tells a scheduler whether the next candidate instruction may join that group. The scheduler describes a candidate on the query port: a unit class, a first-only flag, a single flag and an operation tag. The guard answers in the same cycle with one of three codes. It may say the candidate can go, that it must wait for a fresh group, or that a no-op has to be placed ahead of it.

Once the scheduler has picked an instruction, it commits it on the emit port. An empty slot, such as an inserted no-op or an idle cycle, is spent on the advance port. The guard holds only two pieces of state: the number of slots used in the group, and a flag recording that the counter register was written in this group. Both state values are visible as outputs.

Top module: `dispatch_slot_guard`

## Requirements
- R1: After reset the slot count is 0 and the counter-written flag is clear, so a plain fixed-point query answers 0 (go).
- R2: A group has SLOTS (default 5) slots. The slot count always stays below SLOTS. When it would reach SLOTS it returns to 0 and the counter-written flag clears in the same cycle.
- R3: A non-pseudo query with the first-only flag or the single flag set answers 1 (wait) whenever the slot count is not 0.
- R4: Classes 1 to 5 (fixed-point, load/store, floating-point, vector ALU, vector permute) answer 1 (wait) when the slot count is SLOTS-1, because only a branch may fill the last slot.
- R5: A condition-register query (class 6) answers 1 (wait) when the slot count is CR_SLOTS (default 2) or more.
- R6: A branch query (class 7) is never held back by slot position. With neither flag set, it answers 0 or 2 at every count.
- R7: Emitting a branch (class 7) or a single-flagged instruction closes the group. The count is 0 on the next cycle.
- R8: Emitting an instruction with tag 1 (counter write) sets the counter-written flag. While the flag is set, a query that is not held back and carries tag 2 (branch through counter) answers 2 (no-op needed). Any other tag value is plain.
- R9: Class 0 (pseudo) always answers 0. Emitting it changes neither the count nor the flag.
- R10: An advance adds one to the slot count and wraps as in R2. If emit and advance are both active in a cycle, only the emit takes effect.
- R11: The query answer depends only on the state before any emit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_class | input | 3 | Candidate unit class (0 pseudo … 7 branch) |
| qry_first | input | 1 | Candidate must open a group |
| qry_single | input | 1 | Candidate occupies a whole group |
| qry_tag | input | 2 | Candidate tag: 0 plain, 1 counter write, 2 branch through counter |
| hz_code | output | 2 | 0 go, 1 wait for new group, 2 insert no-op first |
| emt_valid | input | 1 | Commit an instruction this cycle |
| emt_class | input | 3 | Committed unit class |
| emt_single | input | 1 | Committed instruction is single |
| emt_tag | input | 2 | Committed tag, same encoding as qry_tag |
| adv_valid | input | 1 | Spend one empty slot |
| slot_count | output | $clog2(SLOTS) | Slots used in the current group |
| ctr_armed | output | 1 | Counter written in the current group |

## Verification
The properties assume that every input is a known value once reset has been released. They also assume the scheduler may commit any class at any count: the tracker applies the slot arithmetic and never re-checks legality. So the stimulus deliberately emits instructions the query would have refused. It includes emit and advance in the same cycle, and it uses all four tag values, so that both the wrap and the closing path are reached from every count. Directed sequences come first and hit each rule's boundary. Unconstrained mixes then cover the rest.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    typedef enum logic [2:0] {
        UC_PSEUDO = 3'd0,
        UC_FXU    = 3'd1,
        UC_LSU    = 3'd2,
        UC_FPU    = 3'd3,
        UC_VALU   = 3'd4,
        UC_VPERM  = 3'd5,
        UC_CRU    = 3'd6,
        UC_BRU    = 3'd7
    } unit_cls_e;

    typedef enum logic [1:0] {
        TAG_PLAIN  = 2'd0,
        TAG_SETCTR = 2'd1,
        TAG_BRCTR  = 2'd2,
        TAG_RSVD   = 2'd3
    } op_tag_e;

    typedef enum logic [1:0] {
        HZ_GO   = 2'd0,
        HZ_WAIT = 2'd1,
        HZ_NOOP = 2'd2
    } hz_e;

endpackage

// File: rtl/dsg_hazard_eval.sv
module dsg_hazard_eval
    import dsg_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int CR_SLOTS = 2,
    localparam int CW      = $clog2(SLOTS)
) (
    input  logic [CW-1:0] cnt_q,
    input  logic          armed_q,
    input  unit_cls_e     cls,
    input  logic          first_only,
    input  logic          single,
    input  op_tag_e       tag,
    output hz_e           hz
);
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic ordinary;
    logic pos_block;
    logic cr_block;

    always_comb begin
        unique case (cls)
            UC_FXU, UC_LSU, UC_FPU, UC_VALU, UC_VPERM: ordinary = 1'b1;
            default:                                   ordinary = 1'b0;
        endcase
    end

    generate
        if (CR_SLOTS < SLOTS) begin : g_cr_window
            localparam logic [CW-1:0] CR_LIM = CW'(CR_SLOTS);
            assign cr_block = (cls == UC_CRU) && (cnt_q >= CR_LIM);
        end else begin : g_cr_free
            assign cr_block = 1'b0;
        end
    endgenerate

    always_comb begin
        pos_block = 1'b0;
        if ((first_only || single) && (cnt_q != '0)) pos_block = 1'b1;
        if (ordinary && (cnt_q == LAST))             pos_block = 1'b1;
        if (cr_block)                                 pos_block = 1'b1;
    end

    always_comb begin
        hz = HZ_GO;
        if (cls != UC_PSEUDO) begin
            if (pos_block)                            hz = HZ_WAIT;
            else if (armed_q && (tag == TAG_BRCTR))   hz = HZ_NOOP;
        end
    end

endmodule

// File: rtl/dsg_group_track.sv
module dsg_group_track
    import dsg_pkg::*;
#(
    parameter int SLOTS    = 5,
    localparam int CW      = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emt_valid,
    input  unit_cls_e     emt_class,
    input  logic          emt_single,
    input  op_tag_e       emt_tag,
    input  logic          adv_valid,
    output logic [CW-1:0] cnt_q,
    output logic          armed_q
);
    localparam logic [CW:0] FULL  = (CW+1)'(SLOTS);
    localparam logic [CW:0] ONE_W = (CW+1)'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [CW:0] nxt;
    logic        real_emit;
    logic        closes;

    assign real_emit = emt_valid && (emt_class != UC_PSEUDO);
    assign closes    = (emt_class == UC_BRU) || emt_single;

    always_comb begin
        st_d = st_q;
        nxt  = {1'b0, st_q.cnt};
        if (real_emit) begin
            if (emt_tag == TAG_SETCTR) st_d.armed = 1'b1;
            if (closes) nxt = FULL;
            else        nxt = {1'b0, st_q.cnt} + ONE_W;
        end else if (adv_valid) begin
            nxt = {1'b0, st_q.cnt} + ONE_W;
        end
        if (nxt >= FULL) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else begin
            st_d.cnt   = nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign armed_q = st_q.armed;

endmodule

// File: rtl/dispatch_slot_guard.sv
module dispatch_slot_guard
    import dsg_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int CR_SLOTS = 2,
    localparam int CW      = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    qry_class,
    input  logic          qry_first,
    input  logic          qry_single,
    input  logic [1:0]    qry_tag,
    output logic [1:0]    hz_code,
    input  logic          emt_valid,
    input  logic [2:0]    emt_class,
    input  logic          emt_single,
    input  logic [1:0]    emt_tag,
    input  logic          adv_valid,
    output logic [CW-1:0] slot_count,
    output logic          ctr_armed
);
    logic [CW-1:0] cnt_w;
    logic          armed_w;
    hz_e           hz_w;

    dsg_group_track #(.SLOTS(SLOTS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .emt_valid  (emt_valid),
        .emt_class  (unit_cls_e'(emt_class)),
        .emt_single (emt_single),
        .emt_tag    (op_tag_e'(emt_tag)),
        .adv_valid  (adv_valid),
        .cnt_q      (cnt_w),
        .armed_q    (armed_w)
    );

    dsg_hazard_eval #(.SLOTS(SLOTS), .CR_SLOTS(CR_SLOTS)) u_eval (
        .cnt_q      (cnt_w),
        .armed_q    (armed_w),
        .cls        (unit_cls_e'(qry_class)),
        .first_only (qry_first),
        .single     (qry_single),
        .tag        (op_tag_e'(qry_tag)),
        .hz         (hz_w)
    );

    assign hz_code    = hz_w;
    assign slot_count = cnt_w;
    assign ctr_armed  = armed_w;

endmodule

// File: rtl/dsg_props.sv
module dsg_props #(
    parameter int SLOTS    = 5,
    parameter int CR_SLOTS = 2,
    localparam int CW      = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    qry_class,
    input logic          qry_first,
    input logic          qry_single,
    input logic [1:0]    qry_tag,
    input logic [1:0]    hz_code,
    input logic          emt_valid,
    input logic [2:0]    emt_class,
    input logic          emt_single,
    input logic [1:0]    emt_tag,
    input logic          adv_valid,
    input logic [CW-1:0] slot_count,
    input logic          ctr_armed
);
    localparam logic [CW-1:0] LASTC = CW'(SLOTS - 1);
    localparam logic [CW-1:0] CRL   = CW'((CR_SLOTS < SLOTS) ? CR_SLOTS : SLOTS - 1);
    localparam logic [CW-1:0] ONEC  = CW'(1);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_count <= LASTC); // R2

    AST_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_class != 3'd0 && (qry_first || qry_single) && slot_count != '0) |-> hz_code == 2'd1); // R3

    AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_class >= 3'd1 && qry_class <= 3'd5 && slot_count == LASTC) |-> hz_code == 2'd1); // R4

    AST_CR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (CR_SLOTS < SLOTS && qry_class == 3'd6 && slot_count >= CRL) |-> hz_code == 2'd1); // R5

    AST_BRANCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_class == 3'd7 && !qry_first && !qry_single) |-> hz_code != 2'd1); // R6

    AST_GROUP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (emt_valid && (emt_class == 3'd7 || (emt_class != 3'd0 && emt_single)))
            |=> (slot_count == '0 && !ctr_armed)); // R7

    AST_CTR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_armed && qry_class == 3'd7 && !qry_first && !qry_single && qry_tag == 2'd2)
            |-> hz_code == 2'd2); // R8

    AST_PSEUDO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_class == 3'd0) |-> hz_code == 2'd0); // R9

    AST_PSEUDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (emt_valid && emt_class == 3'd0 && !adv_valid)
            |=> ($stable(slot_count) && $stable(ctr_armed))); // R9

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && !emt_valid && slot_count < LASTC)
            |=> slot_count == $past(slot_count) + ONEC); // R10

    AST_ADV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && !emt_valid && slot_count == LASTC)
            |=> (slot_count == '0 && !ctr_armed)); // R2

    AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({hz_code, slot_count, ctr_armed})); // R11

endmodule

bind dispatch_slot_guard dsg_props #(.SLOTS(SLOTS), .CR_SLOTS(CR_SLOTS)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .qry_class  (qry_class),
    .qry_first  (qry_first),
    .qry_single (qry_single),
    .qry_tag    (qry_tag),
    .hz_code    (hz_code),
    .emt_valid  (emt_valid),
    .emt_class  (emt_class),
    .emt_single (emt_single),
    .emt_tag    (emt_tag),
    .adv_valid  (adv_valid),
    .slot_count (slot_count),
    .ctr_armed  (ctr_armed)
);

// File: tb/dispatch_slot_guard_bench.sv
`timescale 1ns/1ps
module dispatch_slot_guard_bench;
    localparam int SLOTS = 5;
    localparam int CRS   = 2;
    localparam int CW    = $clog2(SLOTS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    qry_class = '0;
    logic          qry_first = 1'b0;
    logic          qry_single = 1'b0;
    logic [1:0]    qry_tag = '0;
    logic [1:0]    hz_code;
    logic          emt_valid = 1'b0;
    logic [2:0]    emt_class = '0;
    logic          emt_single = 1'b0;
    logic [1:0]    emt_tag = '0;
    logic          adv_valid = 1'b0;
    logic [CW-1:0] slot_count;
    logic          ctr_armed;

    int n_chk  = 0;
    int n_fail = 0;
    int m_cnt  = 0;
    int m_arm  = 0;

    always #5 clk = ~clk;

    dispatch_slot_guard #(.SLOTS(SLOTS), .CR_SLOTS(CRS)) u_dispatch_slot_guard (
        .clk(clk), .rst_n(rst_n),
        .qry_class(qry_class), .qry_first(qry_first), .qry_single(qry_single),
        .qry_tag(qry_tag), .hz_code(hz_code),
        .emt_valid(emt_valid), .emt_class(emt_class), .emt_single(emt_single),
        .emt_tag(emt_tag), .adv_valid(adv_valid),
        .slot_count(slot_count), .ctr_armed(ctr_armed)
    );

    function automatic int ref_hz(int c, int f, int s, int t);
        if (c == 0) return 0;
        if ((f != 0 || s != 0) && m_cnt != 0) return 1;
        if (c >= 1 && c <= 5 && m_cnt == SLOTS - 1) return 1;
        if (c == 6 && m_cnt >= CRS) return 1;
        if (m_arm != 0 && t == 2) return 2;
        return 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic step(int c, int f, int s, int t, int ev, int ec, int es, int et, int av, string req);
        int n;
        @(negedge clk);
        qry_class = 3'(c); qry_first = f[0]; qry_single = s[0]; qry_tag = 2'(t);
        emt_valid = ev[0]; emt_class = 3'(ec); emt_single = es[0]; emt_tag = 2'(et);
        adv_valid = av[0];
        #1;
        check(req, "hz_code", int'(hz_code), ref_hz(c, f, s, t));
        check(req, "slot_count", int'(slot_count), m_cnt);
        check(req, "ctr_armed", int'(ctr_armed), m_arm);
        @(posedge clk);
        n = m_cnt;
        if (ev != 0 && ec != 0) begin
            if (et == 1) m_arm = 1;
            n = (ec == 7 || es != 0) ? SLOTS : m_cnt + 1;
        end else if (av != 0) begin
            n = m_cnt + 1;
        end
        if (n >= SLOTS) begin m_cnt = 0; m_arm = 0; end
        else m_cnt = n;
    endtask

    task automatic q(int c, int f, int s, int t, string req);
        step(c, f, s, t, 0, 0, 0, 0, 0, req);
    endtask

    task automatic em(int c, int s, int t, string req);
        step(1, 0, 0, 0, 1, c, s, t, 0, req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        q(1, 0, 0, 0, "R1");                       // reset state
        // R3: first-only at count 0 is fine, at count 1 must wait
        q(1, 1, 0, 0, "R3");
        em(2, 0, 0, "R2");                         // count -> 1
        q(1, 1, 0, 0, "R3");
        q(4, 0, 1, 0, "R3");
        // R5: CR at 1 ok, at 2 blocked; R11: query sees pre-emit count
        step(6, 0, 0, 0, 1, 3, 0, 0, 0, "R11");
        q(6, 0, 0, 0, "R5");
        em(5, 0, 0, "R2");                         // count -> 3
        q(5, 0, 0, 0, "R4");
        em(1, 0, 0, "R2");                         // count -> 4
        q(3, 0, 0, 0, "R4");
        q(7, 0, 0, 0, "R6");
        q(0, 1, 1, 2, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10");    // advance wraps to 0
        q(1, 0, 0, 0, "R2");
        // R8: counter write then branch through counter
        em(1, 0, 1, "R8");
        q(7, 0, 0, 2, "R8");
        q(7, 0, 0, 3, "R8");
        em(7, 0, 0, "R7");                         // branch closes group
        q(7, 0, 0, 2, "R8");
        // R7: single closes from count 2
        em(1, 0, 0, "R7"); em(2, 0, 0, "R7");
        em(4, 1, 0, "R7");
        q(1, 0, 0, 0, "R7");
        // R9: pseudo emit changes nothing
        em(1, 0, 1, "R9");
        step(1, 0, 0, 0, 1, 0, 1, 1, 0, "R9");
        q(7, 0, 0, 2, "R9");
        // R10: emit wins over advance
        step(1, 0, 0, 0, 1, 2, 0, 0, 1, "R10");
        q(1, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        q(1, 0, 0, 0, "R10");
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 7), ($urandom_range(0, 5) == 0) ? 1 : 0,
                 ($urandom_range(0, 7) == 0) ? 1 : 0, $urandom_range(0, 3),
                 $urandom_range(0, 1), $urandom_range(0, 7),
                 ($urandom_range(0, 9) == 0) ? 1 : 0, $urandom_range(0, 3),
                 $urandom_range(0, 2) == 0 ? 1 : 0, "R11");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule